// File: doc/BRIEF.md
# Selective Store-Triggered Line Cleaning Controller

This controller sits beside the store path of a write-back data cache and decides, store by store, whether the line just written should be pushed back to memory at once. A small bank of programmable slots each holds one store instruction address and an eight-bit schedule. Every committed store presents its instruction address and data address. When the instruction address equals that of a valid slot, the controller reads the schedule bit that the slot's position counter points at. A set bit sends a clean request for the store's data address, so the cache writes the line back and marks it not dirty; a clear bit lets the store through with no request. In both cases the slot's position counter then moves one step and wraps around. A dirty line that has been cleaned can again be recovered by a reload from the lower memory level if parity detects a fault.

Stores whose instruction address matches no valid slot are never cleaned. The choice of which instructions are listed, and at which of their executions a clean is issued, comes from software that programs the slots through a plain configuration write port.

The store input and the clean output are valid/ready streams. A store is consumed on a cycle where `st_valid` and `st_ready` are both high. `st_ready` drops only when the presented store would need a clean while an earlier clean request is still waiting for `cln_ready`. A stalled store must be held stable. A clean request, once raised, keeps `cln_valid` high and `cln_daddr` unchanged until it is taken with `cln_ready`. `st_ready` does not depend on `st_valid` or on `cln_ready`.

Top module: `clean_sel_ctrl`

## Requirements
- R1: After reset, `cln_valid` is low, `st_ready` is high and every slot is invalid, so no store produces a clean request.
- R2: A store matches a slot only when the slot is valid and its instruction address equals `st_iaddr` exactly. An invalid slot never matches.
- R3: For a consumed matching store, if bit p of the slot's schedule is 1 (p being the slot's position counter, with bit 0 used first after programming), then `cln_valid` is high in the next cycle with `cln_daddr` equal to the store's `st_daddr`. If the bit is 0, no request is raised.
- R4: Each consumed store that a slot wins advances that slot's position counter by one, from 7 back to 0, so the schedule repeats every eight executions.
- R5: A configuration write loads the slot's valid flag, address and schedule and resets its position counter to 0. When a store and a write to the same slot coincide, the store is decided on the old contents and the write takes effect afterwards, counter at 0.
- R6: A store that matches no valid slot never raises a clean request and advances no counter.
- R7: When several valid slots hold the same address, the lowest-numbered one decides and only its counter advances.
- R8: While `cln_valid` is high and `cln_ready` is low, `cln_valid` stays high and `cln_daddr` stays unchanged.
- R9: `st_ready` is low only while a request is pending and the presented store's current schedule bit is 1. Stores that need no clean are consumed even while a request is pending.
- R10: A stalled store is not consumed: no slot counter moves and no new request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | SLOT_W | Slot written by `cfg_we` |
| cfg_vld | input | 1 | Valid flag written into the slot |
| cfg_iaddr | input | IADDR_W | Store instruction address written into the slot |
| cfg_sched | input | SCHED_W | Schedule written into the slot, bit 0 used first |
| st_valid | input | 1 | A committed store is presented |
| st_ready | output | 1 | The controller can consume the presented store |
| st_iaddr | input | IADDR_W | Instruction address of the store |
| st_daddr | input | DADDR_W | Data address written by the store |
| cln_valid | output | 1 | A clean request is pending |
| cln_ready | input | 1 | The cache takes the clean request |
| cln_daddr | output | DADDR_W | Data address of the line to be cleaned |

## Verification
A single slot with an irregular schedule is driven through more than eight executions, which separates a correct bit order and wrap from a reversed or off-by-one counter. Unlisted and invalid addresses interleaved with listed ones show that only exact, valid matches move state, and two slots sharing an address with opposite schedules reveal which one wins. Holding `cln_ready` low while cleaning and non-cleaning stores arrive separates a correct stall from a dropped or lost request, and a long random mix of stores, reprogramming and acknowledge patterns is compared cycle by cycle against a behavioural model.

// File: rtl/clean_sel_pkg.sv
`timescale 1ns/1ps
package clean_sel_pkg;
  typedef enum logic {
    REQ_IDLE = 1'b0,
    REQ_WAIT = 1'b1
  } req_state_e;
endpackage

// File: rtl/clean_sel_slot.sv
`timescale 1ns/1ps
module clean_sel_slot #(
  parameter int IADDR_W = 32,
  parameter int SCHED_W = 8,
  localparam int POS_W  = $clog2(SCHED_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_vld,
  input  logic [IADDR_W-1:0] wr_iaddr,
  input  logic [SCHED_W-1:0] wr_sched,
  input  logic [IADDR_W-1:0] look_iaddr,
  input  logic               step,
  output logic               hit,
  output logic               cur_bit
);
  logic               vld_q;
  logic [IADDR_W-1:0] iaddr_q;
  logic [SCHED_W-1:0] sched_q;
  logic [POS_W-1:0]   pos_q;

  localparam logic [POS_W-1:0] POS_LAST = POS_W'(SCHED_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      iaddr_q <= '0;
      sched_q <= '0;
      pos_q   <= '0;
    end else if (wr_en) begin
      vld_q   <= wr_vld;
      iaddr_q <= wr_iaddr;
      sched_q <= wr_sched;
      pos_q   <= '0;
    end else if (step) begin
      pos_q   <= (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
    end
  end

  assign hit     = vld_q && (iaddr_q == look_iaddr);
  assign cur_bit = sched_q[pos_q];
endmodule

// File: rtl/clean_sel_pick.sv
`timescale 1ns/1ps
module clean_sel_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  always_comb begin
    gnt = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (gnt == '0)) gnt[i] = 1'b1;
    end
  end
  assign any = |req;
endmodule

// File: rtl/clean_sel_req.sv
`timescale 1ns/1ps
module clean_sel_req
  import clean_sel_pkg::*;
#(
  parameter int DADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue,
  input  logic [DADDR_W-1:0] issue_daddr,
  input  logic               take,
  output logic               busy,
  output logic [DADDR_W-1:0] daddr
);
  req_state_e         st_q;
  logic [DADDR_W-1:0] daddr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= REQ_IDLE;
      daddr_q <= '0;
    end else begin
      case (st_q)
        REQ_IDLE: if (issue) begin
          st_q    <= REQ_WAIT;
          daddr_q <= issue_daddr;
        end
        REQ_WAIT: if (take) st_q <= REQ_IDLE;
        default:  st_q <= REQ_IDLE;
      endcase
    end
  end

  assign busy  = (st_q == REQ_WAIT);
  assign daddr = daddr_q;
endmodule

// File: rtl/clean_sel_ctrl.sv
`timescale 1ns/1ps
module clean_sel_ctrl #(
  parameter int NSLOT   = 4,
  parameter int IADDR_W = 32,
  parameter int DADDR_W = 32,
  parameter int SCHED_W = 8,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SLOT_W-1:0]  cfg_slot,
  input  logic               cfg_vld,
  input  logic [IADDR_W-1:0] cfg_iaddr,
  input  logic [SCHED_W-1:0] cfg_sched,
  input  logic               st_valid,
  output logic               st_ready,
  input  logic [IADDR_W-1:0] st_iaddr,
  input  logic [DADDR_W-1:0] st_daddr,
  output logic               cln_valid,
  input  logic               cln_ready,
  output logic [DADDR_W-1:0] cln_daddr
);
  logic [NSLOT-1:0] hit_v, bit_v, grant, step_v;
  logic             any_hit, need_clean, st_take;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic wr_here;
    assign wr_here   = cfg_we && (cfg_slot == SLOT_W'(g));
    assign step_v[g] = st_take && grant[g];
    clean_sel_slot #(.IADDR_W(IADDR_W), .SCHED_W(SCHED_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_here), .wr_vld(cfg_vld), .wr_iaddr(cfg_iaddr), .wr_sched(cfg_sched),
      .look_iaddr(st_iaddr), .step(step_v[g]),
      .hit(hit_v[g]), .cur_bit(bit_v[g])
    );
  end

  clean_sel_pick #(.N(NSLOT)) u_pick (
    .req(hit_v), .gnt(grant), .any(any_hit)
  );

  assign need_clean = |(grant & bit_v);
  assign st_ready   = !(need_clean && cln_valid);
  assign st_take    = st_valid && st_ready;

  clean_sel_req #(.DADDR_W(DADDR_W)) u_req (
    .clk(clk), .rst_n(rst_n),
    .issue(st_take && need_clean), .issue_daddr(st_daddr),
    .take(cln_ready), .busy(cln_valid), .daddr(cln_daddr)
  );
endmodule

// File: rtl/clean_sel_ctrl_chk.sv
`timescale 1ns/1ps
module clean_sel_ctrl_chk #(
  parameter int NSLOT   = 4,
  parameter int DADDR_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               st_valid,
  input logic               st_ready,
  input logic [DADDR_W-1:0] st_daddr,
  input logic               cln_valid,
  input logic               cln_ready,
  input logic [DADDR_W-1:0] cln_daddr,
  input logic               any_hit,
  input logic               need_clean,
  input logic [NSLOT-1:0]   grant
);
  // R8
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cln_valid && !cln_ready |=> cln_valid && $stable(cln_daddr));
  // R3
  issue_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready && need_clean |=> cln_valid && (cln_daddr == $past(st_daddr)));
  // R6
  no_stray_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cln_valid && st_valid && st_ready && !any_hit |=> !cln_valid);
  // R9
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |-> cln_valid && need_clean);
  // R7
  single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any_hit == (grant != '0)));
  // R10
  stall_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cln_valid && !st_ready && !cln_ready |=> $stable(cln_daddr));
endmodule

bind clean_sel_ctrl clean_sel_ctrl_chk #(.NSLOT(NSLOT), .DADDR_W(DADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .st_daddr(st_daddr), .cln_valid(cln_valid), .cln_ready(cln_ready),
  .cln_daddr(cln_daddr), .any_hit(any_hit), .need_clean(need_clean), .grant(grant)
);

// File: tb/clean_sel_ctrl_tb.sv
`timescale 1ns/1ps
module clean_sel_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_slot = '0;
  logic        cfg_vld = 1'b0;
  logic [31:0] cfg_iaddr = '0;
  logic [7:0]  cfg_sched = '0;
  logic        st_valid = 1'b0;
  logic        st_ready;
  logic [31:0] st_iaddr = '0;
  logic [31:0] st_daddr = '0;
  logic        cln_valid;
  logic        cln_ready = 1'b1;
  logic [31:0] cln_daddr;

  always #4 clk = ~clk;

  clean_sel_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_vld(cfg_vld),
    .cfg_iaddr(cfg_iaddr), .cfg_sched(cfg_sched), .st_valid(st_valid), .st_ready(st_ready),
    .st_iaddr(st_iaddr), .st_daddr(st_daddr), .cln_valid(cln_valid), .cln_ready(cln_ready),
    .cln_daddr(cln_daddr)
  );

  // behavioural reference
  logic [31:0] m_ia [4];
  logic [7:0]  m_sc [4];
  bit          m_v  [4];
  int          m_pos[4];
  bit          e_cv;
  logic [31:0] e_da;

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R1";
  bit    last_rdy;
  bit    done = 1'b0;

  function automatic int m_hit(logic [31:0] ia);
    for (int i = 0; i < 4; i++) if (m_v[i] && m_ia[i] == ia) return i;
    return -1;
  endfunction

  function automatic bit m_need(logic [31:0] ia);
    int h;
    h = m_hit(ia);
    return (h >= 0) && m_sc[h][m_pos[h]];
  endfunction

  always @(posedge clk) begin
    int h; bit nd; bit acc;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_v[i] = 0; m_ia[i] = '0; m_sc[i] = '0; m_pos[i] = 0;
      end
      e_cv = 0; e_da = '0;
    end else begin
      h   = m_hit(st_iaddr);
      nd  = m_need(st_iaddr);
      acc = st_valid && !(nd && e_cv);
      if (e_cv && cln_ready) e_cv = 0;
      if (acc && nd) begin e_cv = 1; e_da = st_daddr; end
      if (acc && h >= 0) m_pos[h] = (m_pos[h] + 1) % 8;
      if (cfg_we) begin
        m_v[cfg_slot] = cfg_vld; m_ia[cfg_slot] = cfg_iaddr;
        m_sc[cfg_slot] = cfg_sched; m_pos[cfg_slot] = 0;
      end
    end
  end

  task automatic check_regs();
    vectors++;
    if (cln_valid !== e_cv || (e_cv && cln_daddr !== e_da)) begin
      miscompares++;
      $display("FAIL %s: cln_valid=%0b cln_daddr=%h expected cln_valid=%0b cln_daddr=%h",
               cur_req, cln_valid, cln_daddr, e_cv, e_da);
    end
  endtask

  task automatic check_ready();
    bit er;
    er = !(m_need(st_iaddr) && e_cv);
    last_rdy = er;
    vectors++;
    if (st_ready !== er) begin
      miscompares++;
      $display("FAIL %s: st_ready=%0b expected %0b", cur_req, st_ready, er);
    end
  endtask

  task automatic cyc(bit we, int sl, bit v, logic [31:0] ia, logic [7:0] sc,
                     bit sv, logic [31:0] sia, logic [31:0] sda, bit rdy);
    @(negedge clk);
    check_regs();
    cfg_we = we; cfg_slot = 2'(sl); cfg_vld = v; cfg_iaddr = ia; cfg_sched = sc;
    st_valid = sv; st_iaddr = sia; st_daddr = sda; cln_ready = rdy;
    #1;
    check_ready();
  endtask

  task automatic prog(int sl, bit v, logic [31:0] ia, logic [7:0] sc);
    cyc(1, sl, v, ia, sc, 0, 32'h0, 32'h0, 1);
  endtask

  task automatic store(logic [31:0] ia, logic [31:0] da);
    for (int t = 0; t < 8; t++) begin
      cyc(0, 0, 0, 0, 0, 1, ia, da, 1);
      if (last_rdy) break;
    end
  endtask

  task automatic idle(int n);
    for (int t = 0; t < n; t++) cyc(0, 0, 0, 0, 0, 0, 32'h0, 32'h0, 1);
  endtask

  initial begin
    #(8 * 60000);
    miscompares++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, nothing listed yet
    cur_req = "R1";
    idle(2);
    store(32'h100, 32'hA000); store(32'h0, 32'hA004);
    idle(2);

    // R3 / R4: irregular schedule over ten executions, bit 0 first, wraps after 8
    cur_req = "R3";
    prog(0, 1, 32'h40, 8'b1011_0001);
    for (int k = 0; k < 10; k++) begin
      if (k >= 8) cur_req = "R4";
      store(32'h40, 32'hB000 + 32'(k * 4));
      idle(1);
    end

    // R6: unmatched stores interleaved with a listed one
    cur_req = "R6";
    store(32'h44, 32'hC000); store(32'h41, 32'hC004); store(32'h40, 32'hC008);
    store(32'h3C, 32'hC00C); idle(2);

    // R2: invalid slot never matches
    cur_req = "R2";
    prog(1, 0, 32'h80, 8'hFF);
    store(32'h80, 32'hD000); store(32'h80, 32'hD004); idle(2);

    // R7: duplicate addresses, lowest slot decides
    cur_req = "R7";
    prog(2, 1, 32'h90, 8'hFF);
    prog(3, 1, 32'h90, 8'h00);
    store(32'h90, 32'hE000); idle(1); store(32'h90, 32'hE004); idle(1);
    prog(2, 0, 32'h90, 8'hFF);
    store(32'h90, 32'hE008); store(32'h90, 32'hE00C); idle(2);
    prog(2, 1, 32'h90, 8'b0000_0100);
    store(32'h90, 32'hE010); store(32'h90, 32'hE014); store(32'h90, 32'hE018); idle(2);

    // R5: reprogram resets position; coincident store uses old contents
    cur_req = "R5";
    prog(0, 1, 32'h40, 8'b0000_0011);
    store(32'h40, 32'hF000); idle(1);
    prog(0, 1, 32'h40, 8'b0000_0010);
    store(32'h40, 32'hF004); store(32'h40, 32'hF008); idle(1);
    cyc(1, 0, 1, 32'h40, 8'b0000_0001, 1, 32'h40, 32'hF00C, 1);
    store(32'h40, 32'hF010); idle(2);

    // R8 / R9 / R10: acknowledge withheld
    cur_req = "R8";
    prog(0, 1, 32'h40, 8'hFF);
    cyc(0, 0, 0, 0, 0, 1, 32'h40, 32'h1000, 0);
    for (int t = 0; t < 3; t++) cyc(0, 0, 0, 0, 0, 0, 32'h0, 32'h0, 0);
    cur_req = "R10";
    for (int t = 0; t < 3; t++) cyc(0, 0, 0, 0, 0, 1, 32'h40, 32'h2000, 0);
    cur_req = "R9";
    cyc(0, 0, 0, 0, 0, 1, 32'h44, 32'h3000, 0);
    cyc(0, 0, 0, 0, 0, 1, 32'h90, 32'h3004, 0);
    cyc(0, 0, 0, 0, 0, 1, 32'h40, 32'h2000, 1);
    cyc(0, 0, 0, 0, 0, 1, 32'h40, 32'h2000, 0);
    idle(3);

    // random mix
    cur_req = "R4";
    for (int t = 0; t < 4000; t++) begin
      int r; bit we; logic [31:0] ia;
      r  = $urandom_range(0, 99);
      we = (r < 4);
      ia = 32'h40 + 32'($urandom_range(0, 3) * 16);
      cyc(we, $urandom_range(0, 3), $urandom_range(0, 4) != 0, ia, 8'($urandom),
          $urandom_range(0, 2) != 0, 32'h40 + 32'($urandom_range(0, 4) * 16),
          32'($urandom), $urandom_range(0, 2) != 0);
    end
    idle(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule